// File: doc/BRIEF.md
# Serial DAC Register Front End with Clear Mode

This block is the digital front end of a serially programmed precision DAC. A host shifts 32-bit write frames in on a serial clock while an active-low frame select is held low. The block samples the serial pins with its own system clock, checks that each frame carries exactly 32 bits, and writes the addressed entry of a small register file. It drives a 20-bit code into the converter latch, shows the input buffer that feeds that latch, and passes the two configuration words on to the converter core.

Clear mode forces the buffer and the latch to a programmed clear code. There are two ways to enter it. The first is an active-low clear pin, which acts on the output code at once and without a clock. The second is a software clear bit in the trigger register, which acts when the frame that sets it ends. Clear mode stays active until a later valid write frame ends while the pin is high.

Frame layout, MSB first: bit 31 is the direction flag (1 = read, 0 = write), bits 30:24 are the register address, and bits 23:0 are the data. Register addresses:

| Address | Register |
|---------|----------|
| 0x00 | no operation |
| 0x01 | DAC data |
| 0x02 | configuration word A |
| 0x03 | clear code |
| 0x04 | trigger |
| 0x05 | status (read only) |
| 0x06 | configuration word B |

Top module: `dac_frontend`

## Requirements
- R1: While `rst` is high and after it is released, `dac_code` and `dac_buf` are 0, `clear_mode` is 0, `cfg_a` is 0x004C80 and `cfg_b` is 0x000040.
- R2: A valid write frame to address 0x01 loads bits 23:4 of its data into `dac_buf`. It also loads them into `dac_code` when the frame ends, provided clear mode is not active. Data bits 3:0 have no effect.
- R3: A frame with any clock count other than 32 between the falling and rising edges of `sync_n` is discarded. No register and no output changes, and clear mode is not left.
- R4: A frame with bit 31 set (read) changes no register and does not leave clear mode.
- R5: A valid write to address 0x02 replaces all 24 bits of `cfg_a`, and a write to address 0x06 replaces all 24 bits of `cfg_b`. A write to 0x03 stores bits 23:4 as the clear code without changing `dac_code`. Writes to 0x05 and to unmapped addresses are ignored.
- R6: While `clr_n` is low, `dac_code` equals the clear code with no clock delay, and `dac_buf` is held at the clear code. `clear_mode` reads 1 no later than 3 clock cycles after the fall.
- R7: A low level on `clr_n` in the middle of a frame clears the outputs immediately. A frame that ends while `clr_n` is still low leaves clear mode set.
- R8: A valid write to address 0x04 with data bit 5 set loads the clear code into the buffer and the latch when the frame ends, and sets `clear_mode`.
- R9: Clear mode stays set after `clr_n` returns high. It is left only when a valid write frame ends. If that frame writes DAC data, `dac_buf` takes the new code and `dac_code` keeps the clear code.
- R10: `clr_status` is the level of `clr_n` after a two-flop synchronizer, and follows the pin within 3 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data, MSB first |
| clr_n | input | 1 | Asynchronous active-low clear pin |
| dac_code | output | 20 | Code driven to the converter latch |
| dac_buf | output | 20 | Input buffer that feeds the latch |
| clear_mode | output | 1 | Clear mode is active |
| clr_status | output | 1 | Synchronized level of the clear pin |
| cfg_a | output | 24 | Configuration word A |
| cfg_b | output | 24 | Configuration word B |

## Verification
The checker watches several rules on every clock cycle:
- a low synchronized clear level always sets clear mode;
- clear mode falls only right after a frame commit;
- a software clear commit always sets clear mode;
- the latch holds still whenever no commit and no clear is pending;
- reset returns the configuration defaults.

Other behaviour can only be shown by the bench's scenarios:
- that the pin reaches `dac_code` with no clock delay;
- that frames of the wrong length and read frames leave every register untouched;
- that bits 3:0 of the data are dropped;
- the mid-frame clear;
- that clear mode persists until the next valid write.

// File: rtl/dac_frontend_pkg.sv
package dac_frontend_pkg;
    localparam int FRAME_BITS = 32;
    localparam int DATA_W     = 24;
    localparam int ADDR_W     = 7;
    localparam int CODE_W     = 20;
    localparam int CNT_W      = $clog2(FRAME_BITS) + 1;
    localparam int SWCLR_BIT  = 5;

    localparam logic [DATA_W-1:0] RST_CFG_A = 24'h004C80;
    localparam logic [DATA_W-1:0] RST_CFG_B = 24'h000040;

    typedef enum logic [ADDR_W-1:0] {
        ADR_NOP   = 7'h00,
        ADR_CODE  = 7'h01,
        ADR_CFGA  = 7'h02,
        ADR_CLRC  = 7'h03,
        ADR_TRIG  = 7'h04,
        ADR_STAT  = 7'h05,
        ADR_CFGB  = 7'h06
    } reg_addr_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [CODE_W-1:0] code_of(input logic [DATA_W-1:0] d);
        return d[DATA_W-1 -: CODE_W];
    endfunction
endpackage

// File: rtl/dac_frontend_sync.sv
module dac_frontend_sync #(
    parameter int               W      = 1,
    parameter int               STAGES = 2,
    parameter logic [W-1:0]     INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= INIT;
                else     stage[i] <= (i == 0) ? d : stage[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dac_frontend_deser.sv
module dac_frontend_deser
    import dac_frontend_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk,
    input  logic   sync_n,
    input  logic   sdin,
    output logic   commit,
    output frame_t word
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic [2:0]            pins_s;
    logic                  sclk_s, sync_s, sdin_s;
    logic                  sclk_d, sync_d;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sh;

    dac_frontend_sync #(.W(3), .STAGES(2), .INIT(3'b110)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, sync_n, sdin}),
        .q   (pins_s)
    );
    assign {sclk_s, sync_s, sdin_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b1;
            sync_d <= 1'b1;
            cnt    <= '0;
            sh     <= '0;
            commit <= 1'b0;
            word   <= '0;
        end else begin
            commit <= 1'b0;
            sclk_d <= sclk_s;
            sync_d <= sync_s;
            if (sync_d && !sync_s) begin
                cnt <= '0;
            end else if (!sync_s && sclk_d && !sclk_s) begin
                sh <= {sh[FRAME_BITS-2:0], sdin_s};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (!sync_d && sync_s && cnt == CNT_FULL && !sh[FRAME_BITS-1]) begin
                commit <= 1'b1;
                word   <= frame_t'(sh);
            end
        end
    end
endmodule

// File: rtl/dac_frontend_regs.sv
module dac_frontend_regs
    import dac_frontend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  frame_t            word,
    input  logic              clr_low,
    output logic [CODE_W-1:0] latch_q,
    output logic [CODE_W-1:0] buf_q,
    output logic [CODE_W-1:0] clr_code,
    output logic              clear_mode,
    output logic [DATA_W-1:0] cfg_a,
    output logic [DATA_W-1:0] cfg_b
);
    logic sw_clr;
    assign sw_clr = commit && word.addr == ADR_TRIG && word.data[SWCLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q    <= '0;
            buf_q      <= '0;
            clr_code   <= '0;
            clear_mode <= 1'b0;
            cfg_a      <= RST_CFG_A;
            cfg_b      <= RST_CFG_B;
        end else begin
            if (commit) begin
                unique case (word.addr)
                    ADR_CODE: begin
                        buf_q <= code_of(word.data);
                        if (!clear_mode) latch_q <= code_of(word.data);
                    end
                    ADR_CFGA: cfg_a    <= word.data;
                    ADR_CLRC: clr_code <= code_of(word.data);
                    ADR_CFGB: cfg_b    <= word.data;
                    ADR_TRIG: if (word.data[SWCLR_BIT]) begin
                        buf_q   <= clr_code;
                        latch_q <= clr_code;
                    end
                    default: ;
                endcase
                clear_mode <= sw_clr;
            end
            if (clr_low) begin
                buf_q      <= clr_code;
                latch_q    <= clr_code;
                clear_mode <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dac_frontend.sv
module dac_frontend
    import dac_frontend_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdin,
    input  logic              clr_n,
    output logic [19:0]       dac_code,
    output logic [19:0]       dac_buf,
    output logic              clear_mode,
    output logic              clr_status,
    output logic [23:0]       cfg_a,
    output logic [23:0]       cfg_b
);
    logic              commit;
    frame_t            word;
    logic [CODE_W-1:0] latch_q, clr_code;

    dac_frontend_sync #(.W(1), .STAGES(2), .INIT(1'b1)) u_clr_sync (
        .clk (clk),
        .rst (rst),
        .d   (clr_n),
        .q   (clr_status)
    );

    dac_frontend_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .sclk   (sclk),
        .sync_n (sync_n),
        .sdin   (sdin),
        .commit (commit),
        .word   (word)
    );

    dac_frontend_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .word       (word),
        .clr_low    (!clr_status),
        .latch_q    (latch_q),
        .buf_q      (dac_buf),
        .clr_code   (clr_code),
        .clear_mode (clear_mode),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b)
    );

    // The pin overrides the latch without a clock edge.
    assign dac_code = clr_n ? latch_q : clr_code;
endmodule

// File: rtl/dac_frontend_checker.sv
module dac_frontend_checker
    import dac_frontend_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              commit,
    input frame_t            word,
    input logic              clr_status,
    input logic              clear_mode,
    input logic [CODE_W-1:0] latch_q,
    input logic [DATA_W-1:0] cfg_a,
    input logic [DATA_W-1:0] cfg_b
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (cfg_a == RST_CFG_A && cfg_b == RST_CFG_B && !clear_mode)); // R1

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (clr_status && !commit) |=> $stable(latch_q)); // R3

    AST_PIN_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
        !clr_status |=> clear_mode); // R6

    AST_SWCLR_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
        (commit && word.addr == ADR_TRIG && word.data[SWCLR_BIT]) |=> clear_mode); // R8

    AST_EXIT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(clear_mode) |-> $past(commit)); // R9
endmodule

bind dac_frontend dac_frontend_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .word       (word),
    .clr_status (clr_status),
    .clear_mode (clear_mode),
    .latch_q    (latch_q),
    .cfg_a      (cfg_a),
    .cfg_b      (cfg_b)
);

// File: tb/dac_frontend_test.sv
`timescale 1ns/1ps
module dac_frontend_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, clr_n = 1'b1;
    logic [19:0] dac_code, dac_buf;
    logic        clear_mode, clr_status;
    logic [23:0] cfg_a, cfg_b;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [19:0] e_lat, e_buf, e_clr;
    logic        e_mode;
    logic [23:0] e_cfga, e_cfgb;

    always #10 clk = ~clk;

    dac_frontend uut (
        .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .clr_n(clr_n), .dac_code(dac_code), .dac_buf(dac_buf),
        .clear_mode(clear_mode), .clr_status(clr_status),
        .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [6:0] a, input logic [23:0] d);
        return {rd, a, d};
    endfunction

    task automatic shift_bits(input logic [31:0] w, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            sclk = 1'b1;
            sdin = (i < 32) ? w[31-i] : 1'b0;
            wclk(4);
            sclk = 1'b0;
            wclk(4);
        end
    endtask

    task automatic open_frame();
        sync_n = 1'b0;
        wclk(4);
    endtask

    task automatic close_frame();
        sclk = 1'b1;
        wclk(4);
        sync_n = 1'b1;
        wclk(10);
    endtask

    // Bench model of a frame ending with the given clock count
    task automatic model(input logic [31:0] w, input int n);
        logic [23:0] d;
        d = w[23:0];
        if (n != 32 || w[31]) return;
        case (w[30:24])
            7'h01: begin e_buf = d[23:4]; if (!e_mode) e_lat = d[23:4]; end
            7'h02: e_cfga = d;
            7'h03: e_clr = d[23:4];
            7'h06: e_cfgb = d;
            default: ;
        endcase
        if (w[30:24] == 7'h04 && d[5]) begin
            e_buf = e_clr; e_lat = e_clr; e_mode = 1'b1;
        end else begin
            e_mode = 1'b0;
        end
        if (!clr_n) begin
            e_buf = e_clr; e_lat = e_clr; e_mode = 1'b1;
        end
    endtask

    task automatic send(input logic [31:0] w, input int n);
        open_frame();
        shift_bits(w, 0, n);
        close_frame();
        model(w, n);
    endtask

    task automatic check_all(input string req);
        chk(req, {12'h0, dac_code}, {12'h0, clr_n ? e_lat : e_clr});
        chk(req, {12'h0, dac_buf}, {12'h0, e_buf});
        chk(req, {31'h0, clear_mode}, {31'h0, e_mode});
        chk(req, {8'h0, cfg_a}, {8'h0, e_cfga});
        chk(req, {8'h0, cfg_b}, {8'h0, e_cfgb});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        logic [31:0] w;
        int n;
        seed = 32'd7;
        void'($urandom(seed));
        e_lat = '0; e_buf = '0; e_clr = '0; e_mode = 1'b0;
        e_cfga = 24'h004C80; e_cfgb = 24'h000040;

        wclk(3);
        check_all("R1 in reset");
        rst = 1'b0;
        wclk(3);
        check_all("R1 after reset");
        chk("R10 idle", {31'h0, clr_status}, 32'h1);

        // R2: data write, low nibble ignored
        send(mk(0, 7'h01, 24'hABCDEF), 32);
        chk("R2 code", {12'h0, dac_code}, 32'h000ABCDE);
        check_all("R2");

        // R3: short and long frames discarded
        send(mk(0, 7'h01, 24'h123456), 31);
        check_all("R3 short");
        send(mk(0, 7'h02, 24'h111111), 33);
        check_all("R3 long");

        // R4: read frame ignored
        send(mk(1, 7'h01, 24'h555550), 32);
        check_all("R4");

        // R5: configuration and clear code
        send(mk(0, 7'h02, 24'hA5A5A5), 32);
        send(mk(0, 7'h06, 24'h5A5A5A), 32);
        send(mk(0, 7'h03, 24'h13579F), 32);
        send(mk(0, 7'h05, 24'hFFFFFF), 32);
        send(mk(0, 7'h07, 24'hFFFFFF), 32);
        check_all("R5");
        chk("R5 clear write no output change", {12'h0, dac_code}, 32'h000ABCDE);

        // R6/R10: pin clear
        clr_n = 1'b0;
        #1;
        chk("R6 immediate", {12'h0, dac_code}, 32'h00013579);
        wclk(3);
        chk("R6 mode", {31'h0, clear_mode}, 32'h1);
        chk("R10 low", {31'h0, clr_status}, 32'h0);
        e_buf = e_clr; e_lat = e_clr; e_mode = 1'b1;
        check_all("R6");
        clr_n = 1'b1;
        wclk(4);
        chk("R10 high", {31'h0, clr_status}, 32'h1);
        check_all("R9 held after release");
        send(mk(0, 7'h01, 24'h000010), 31);
        check_all("R9 bad frame no exit");
        send(mk(1, 7'h00, 24'h0), 32);
        check_all("R4 read no exit");
        // R9: data write exits mode, latch keeps clear code
        send(mk(0, 7'h01, 24'h222220), 32);
        chk("R9 latch kept", {12'h0, dac_code}, 32'h00013579);
        chk("R9 buffer", {12'h0, dac_buf}, 32'h00022222);
        chk("R9 exit", {31'h0, clear_mode}, 32'h0);
        send(mk(0, 7'h01, 24'h333330), 32);
        check_all("R9 next write");

        // R7: clear arrives mid-frame
        w = mk(0, 7'h01, 24'h777770);
        open_frame();
        shift_bits(w, 0, 10);
        clr_n = 1'b0;
        #1;
        chk("R7 immediate", {12'h0, dac_code}, {12'h0, e_clr});
        wclk(1);
        shift_bits(w, 10, 32);
        close_frame();
        model(w, 32);
        check_all("R7 frame under clear");
        clr_n = 1'b1;
        wclk(4);
        check_all("R7 mode held");
        send(mk(0, 7'h00, 24'h0), 32);
        check_all("R7 exit by nop");

        // R8: software clear
        send(mk(0, 7'h01, 24'h444440), 32);
        send(mk(0, 7'h04, 24'h000020), 32);
        chk("R8 code", {12'h0, dac_code}, {12'h0, e_clr});
        chk("R8 mode", {31'h0, clear_mode}, 32'h1);
        check_all("R8");
        send(mk(0, 7'h04, 24'h000000), 32);
        check_all("R8 trigger without bit exits");

        // Random mix
        for (int k = 0; k < 150; k++) begin
            logic [6:0] a;
            logic [23:0] d;
            a = 7'($urandom % 8);
            d = 24'($urandom);
            if (a == 7'h04 && ($urandom % 2) == 0) d[5] = 1'b0;
            n = (($urandom % 8) == 0) ? (($urandom % 2) ? 31 : 33) : 32;
            send(mk(($urandom % 8) == 0, a, d), n);
            check_all("R2 R3 R4 R5 R8 R9 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule